// File: doc/BRIEF.md
# Outstanding Request Age Watchdog

This block watches two request tables of a memory request merging unit: one holding packets that still wait to be merged, one holding merged requests that wait for a response. Each entry presents a valid bit and the timestamp of its issue. A free-running cycle counter is supplied as the current time. An entry is stale when its age, the current time minus its issue timestamp, is strictly greater than a programmable threshold.

The watchdog is not always running. A request issue arms it, but only if no check is already pending. The scan then starts one threshold period later and walks one entry per cycle. It visits the merged-request table first and the waiting-packet table after it. The first stale entry it finds raises a fatal deadlock flag and records which table and entry it was. The flag and the index hold until reset. When a scan finds nothing stale, a new period starts only while the outstanding-request count is non-zero. Otherwise the block goes idle until the next issue.

Top module: `req_age_watchdog`

## Requirements
- R1: After reset `deadlock_o` is 0, `dl_table_o` is 0 and `dl_entry_o` is 0. With no `issue_i` pulse, no scan takes place, so even stale valid entries never raise the flag.
- R2: An entry is flagged only when `(now_i - ts) > thresh_i`. The comparison is strict, so an age equal to the threshold is not flagged.
- R3: In the idle state, an `issue_i` with a non-zero threshold T, sampled at clock edge e0, arms the watchdog. The entry at scan position p is then examined at edge e0+T+1+p, using `now_i` and `thresh_i` as sampled at that edge. If that entry is stale, `deadlock_o` is 1 after that edge and was 0 before it.
- R4: An `issue_i` while a check is pending or a scan is in progress is ignored. It does not restart the period.
- R5: An `issue_i` while `thresh_i` is 0 does not arm the watchdog, so no flag is ever raised from it.
- R6: Scan positions 0..N_CO-1 are merged-request entries 0..N_CO-1. Positions N_CO..N_CO+N_UC-1 are waiting-packet entries 0..N_UC-1. The first stale position is reported. `dl_table_o` is 0 for the merged-request table and 1 for the waiting-packet table, and `dl_entry_o` is the entry number within that table.
- R7: A scan that finds nothing stale examines its last position at edge eL. If `outstanding_i` is non-zero at eL, a new period of the current threshold starts there, and the next scan examines position p at eL+T+1+p. If `outstanding_i` is 0, the watchdog goes idle.
- R8: Once `deadlock_o` is 1, it stays 1 together with `dl_table_o` and `dl_entry_o` until reset, whatever the later stimulus.
- R9: An entry whose valid bit is 0 is never flagged, whatever its timestamp.
- R10: Age is computed modulo 2^TS_W, so a timestamp taken just before the counter wraps still yields the true small age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| thresh_i | input | TS_W | Age threshold and check period, in cycles |
| now_i | input | TS_W | Free-running cycle counter |
| issue_i | input | 1 | A request was issued this cycle |
| outstanding_i | input | CNT_W | Number of requests still outstanding |
| co_valid_i | input | N_CO | Merged-request table valid bits |
| co_ts_i | input | N_CO*TS_W | Merged-request issue timestamps, entry i at bits i*TS_W |
| uc_valid_i | input | N_UC | Waiting-packet table valid bits |
| uc_ts_i | input | N_UC*TS_W | Waiting-packet issue timestamps, entry i at bits i*TS_W |
| deadlock_o | output | 1 | Sticky deadlock flag |
| dl_table_o | output | 1 | Table of the stale entry: 0 merged, 1 waiting |
| dl_entry_o | output | POS_W | Entry number of the stale entry within its table |

## Verification
The bench builds the block with 4 merged-request entries, 6 waiting-packet entries, 8-bit timestamps and a 4-bit outstanding count. The 8-bit time base lets the counter wrap within a few hundred cycles, so modular age is exercised directly. The unequal table sizes make the table boundary in the scan order visible. Small thresholds keep each period short, so many armed scans, rearmed scans and strict-boundary ages fit into one run.

// File: rtl/raw_pkg.sv
package raw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SCAN = 2'd2,
    ST_HALT = 2'd3
  } raw_state_e;

  typedef enum logic {
    TBL_CO = 1'b0,
    TBL_UC = 1'b1
  } raw_table_e;
endpackage

// File: rtl/raw_period_timer.sv
module raw_period_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] period_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= period_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign expire_o = (cnt_q == W'(1));
endmodule

// File: rtl/raw_entry_sel.sv
module raw_entry_sel #(
  parameter int N     = 8,
  parameter int TS_W  = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]      valid_i,
  input  logic [N*TS_W-1:0] ts_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              valid_o,
  output logic [TS_W-1:0]   ts_o
);
  always_comb begin
    valid_o = 1'b0;
    ts_o    = '0;
    for (int i = 0; i < N; i++) begin
      if (idx_i == IDX_W'(i)) begin
        valid_o = valid_i[i];
        ts_o    = ts_i[i*TS_W +: TS_W];
      end
    end
  end
endmodule

// File: rtl/raw_age_cmp.sv
module raw_age_cmp #(
  parameter int W = 16
) (
  input  logic         valid_i,
  input  logic [W-1:0] ts_i,
  input  logic [W-1:0] now_i,
  input  logic [W-1:0] limit_i,
  output logic         stale_o
);
  logic [W-1:0] age;

  // modular difference survives counter wrap
  assign age     = now_i - ts_i;
  assign stale_o = valid_i && (age > limit_i);
endmodule

// File: rtl/req_age_watchdog.sv
module req_age_watchdog
  import raw_pkg::*;
#(
  parameter int N_CO  = 8,
  parameter int N_UC  = 8,
  parameter int TS_W  = 16,
  parameter int CNT_W = 8,
  localparam int NT    = N_CO + N_UC,
  localparam int POS_W = $clog2(NT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TS_W-1:0]   thresh_i,
  input  logic [TS_W-1:0]   now_i,
  input  logic              issue_i,
  input  logic [CNT_W-1:0]  outstanding_i,
  input  logic [N_CO-1:0]   co_valid_i,
  input  logic [N_CO*TS_W-1:0] co_ts_i,
  input  logic [N_UC-1:0]   uc_valid_i,
  input  logic [N_UC*TS_W-1:0] uc_ts_i,
  output logic              deadlock_o,
  output logic              dl_table_o,
  output logic [POS_W-1:0]  dl_entry_o
);
  raw_state_e       state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             dl_q, dl_d;
  raw_table_e       tbl_q, tbl_d;
  logic [POS_W-1:0] ent_q, ent_d;

  logic             thresh_ok, expire, load;
  logic             in_co, last_pos;
  logic [POS_W-1:0] uc_off;
  logic             co_sel_v, uc_sel_v, co_stale, uc_stale, cur_stale;
  logic [TS_W-1:0]  co_sel_ts, uc_sel_ts;

  assign thresh_ok = (thresh_i != '0);
  assign in_co     = (pos_q < POS_W'(N_CO));
  assign last_pos  = (pos_q == POS_W'(NT - 1));
  assign uc_off    = pos_q - POS_W'(N_CO);

  raw_entry_sel #(.N(N_CO), .TS_W(TS_W), .IDX_W(POS_W)) u_co_sel (
    .valid_i (co_valid_i),
    .ts_i    (co_ts_i),
    .idx_i   (pos_q),
    .valid_o (co_sel_v),
    .ts_o    (co_sel_ts)
  );

  raw_entry_sel #(.N(N_UC), .TS_W(TS_W), .IDX_W(POS_W)) u_uc_sel (
    .valid_i (uc_valid_i),
    .ts_i    (uc_ts_i),
    .idx_i   (uc_off),
    .valid_o (uc_sel_v),
    .ts_o    (uc_sel_ts)
  );

  raw_age_cmp #(.W(TS_W)) u_co_cmp (
    .valid_i (co_sel_v),
    .ts_i    (co_sel_ts),
    .now_i   (now_i),
    .limit_i (thresh_i),
    .stale_o (co_stale)
  );

  raw_age_cmp #(.W(TS_W)) u_uc_cmp (
    .valid_i (uc_sel_v),
    .ts_i    (uc_sel_ts),
    .now_i   (now_i),
    .limit_i (thresh_i),
    .stale_o (uc_stale)
  );

  assign cur_stale = in_co ? co_stale : uc_stale;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    dl_d    = dl_q;
    tbl_d   = tbl_q;
    ent_d   = ent_q;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (issue_i && thresh_ok) begin
          load    = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (expire) begin
          state_d = ST_SCAN;
          pos_d   = '0;
        end
      end
      ST_SCAN: begin
        if (cur_stale) begin
          state_d = ST_HALT;
          dl_d    = 1'b1;
          tbl_d   = in_co ? TBL_CO : TBL_UC;
          ent_d   = in_co ? pos_q : uc_off;
        end else if (last_pos) begin
          if ((outstanding_i != '0) && thresh_ok) begin
            load    = 1'b1;
            state_d = ST_WAIT;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          pos_d = pos_q + POS_W'(1);
        end
      end
      default: ;  // ST_HALT holds until reset
    endcase
  end

  raw_period_timer #(.W(TS_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .period_i (thresh_i),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      dl_q    <= 1'b0;
      tbl_q   <= TBL_CO;
      ent_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      dl_q    <= dl_d;
      tbl_q   <= tbl_d;
      ent_q   <= ent_d;
    end
  end

  assign deadlock_o = dl_q;
  assign dl_table_o = tbl_q;
  assign dl_entry_o = ent_q;
endmodule

// File: rtl/raw_checker.sv
module raw_checker
  import raw_pkg::*;
#(
  parameter int N_CO  = 8,
  parameter int N_UC  = 8,
  parameter int TS_W  = 16,
  parameter int POS_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_i,
  input logic [TS_W-1:0]  thresh_i,
  input raw_state_e       state_i,
  input logic             deadlock_o,
  input logic             dl_table_o,
  input logic [POS_W-1:0] dl_entry_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_HALT) |-> !deadlock_o);  // R1

  AST_ARM_ON_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && issue_i && thresh_i != '0) |=> (state_i == ST_WAIT));  // R3

  AST_PENDING_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT) |=> (state_i == ST_WAIT || state_i == ST_SCAN));  // R4

  AST_ZERO_THRESH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && thresh_i == '0) |=> (state_i == ST_IDLE));  // R5

  AST_FLAG_FROM_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deadlock_o) |-> ($past(state_i) == ST_SCAN));  // R6

  AST_ENTRY_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deadlock_o |-> (dl_table_o ? (int'(dl_entry_o) < N_UC) : (int'(dl_entry_o) < N_CO)));  // R6

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deadlock_o |=> (deadlock_o && $stable(dl_table_o) && $stable(dl_entry_o)));  // R8
endmodule

bind req_age_watchdog raw_checker #(
  .N_CO(N_CO), .N_UC(N_UC), .TS_W(TS_W), .POS_W(POS_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .issue_i    (issue_i),
  .thresh_i   (thresh_i),
  .state_i    (state_q),
  .deadlock_o (deadlock_o),
  .dl_table_o (dl_table_o),
  .dl_entry_o (dl_entry_o)
);

// File: tb/req_age_watchdog_tb.sv
`timescale 1ns/1ps
module req_age_watchdog_tb;
  localparam int N_CO = 4, N_UC = 6, TS_W = 8, CNT_W = 4;
  localparam int NT = N_CO + N_UC, POS_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TS_W-1:0] thresh = '0;
  logic issue = 1'b0;
  logic [CNT_W-1:0] outst = '0;
  logic [N_CO-1:0] co_valid = '0;
  logic [N_CO*TS_W-1:0] co_ts = '0;
  logic [N_UC-1:0] uc_valid = '0;
  logic [N_UC*TS_W-1:0] uc_ts = '0;
  logic deadlock, dl_table;
  logic [POS_W-1:0] dl_entry;
  logic [31:0] cyc = '0;
  logic [TS_W-1:0] now;

  int n_chk = 0, n_err = 0;
  int age_a[NT];
  bit vld_a[NT];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 32'd1;
  assign now = cyc[TS_W-1:0];

  req_age_watchdog #(.N_CO(N_CO), .N_UC(N_UC), .TS_W(TS_W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .thresh_i(thresh), .now_i(now), .issue_i(issue),
    .outstanding_i(outst), .co_valid_i(co_valid), .co_ts_i(co_ts),
    .uc_valid_i(uc_valid), .uc_ts_i(uc_ts),
    .deadlock_o(deadlock), .dl_table_o(dl_table), .dl_entry_o(dl_entry));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int first_stale(input int t);
    for (int p = 0; p < NT; p++)
      if (vld_a[p] && age_a[p] > t) return p;
    return -1;
  endfunction

  task automatic clear_model();
    for (int p = 0; p < NT; p++) begin
      vld_a[p] = 1'b0;
      age_a[p] = 0;
    end
  endtask

  // entry p gets the given age at the edge that examines it
  task automatic set_entry(input int p, input logic [31:0] now_at);
    logic [31:0] v;
    v = now_at - 32'(age_a[p]);
    if (p < N_CO) begin
      co_valid[p] = vld_a[p];
      co_ts[p*TS_W +: TS_W] = v[TS_W-1:0];
    end else begin
      uc_valid[p-N_CO] = vld_a[p];
      uc_ts[(p-N_CO)*TS_W +: TS_W] = v[TS_W-1:0];
    end
  endtask

  task automatic apply_tables(input int t, input logic [31:0] c0);
    for (int p = 0; p < NT; p++) set_entry(p, c0 + 32'(t) + 32'(p));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; issue = 1'b0; outst = '0; thresh = '0;
    co_valid = '0; uc_valid = '0; co_ts = '0; uc_ts = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_issue();
    @(negedge clk) issue = 1'b1;
    @(negedge clk) issue = 1'b0;
  endtask

  task automatic expect_hit(input int p, input string req);
    int et, ei;
    et = (p >= N_CO) ? 1 : 0;
    ei = (p >= N_CO) ? p - N_CO : p;
    check(deadlock === 1'b1, req, int'(deadlock), 1);
    check(dl_table === et[0], req, int'(dl_table), et);
    check(int'(dl_entry) == ei, req, int'(dl_entry), ei);
  endtask

  // R3: arm on issue, then examine position p at e0+T+1+p
  task automatic run_scan(input int t, input string req);
    logic [31:0] c0;
    int e;
    thresh = TS_W'(t);
    pulse_issue();
    c0 = cyc;
    apply_tables(t, c0);
    e = first_stale(t);
    if (e >= 0) begin
      repeat (t + e) @(negedge clk);
      check(deadlock === 1'b0, {req, " R3 early"}, int'(deadlock), 0);
      @(negedge clk);
      expect_hit(e, req);
    end else begin
      repeat (t + NT + 2) @(negedge clk);
      check(deadlock === 1'b0, req, int'(deadlock), 0);
    end
  endtask

  initial begin
    #500000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] c0;
    void'($urandom(32'h5eed_0c01));

    // R1: reset values, and no scan without an issue
    do_reset();
    check(deadlock === 1'b0, "R1", int'(deadlock), 0);
    check(dl_table === 1'b0, "R1", int'(dl_table), 0);
    check(dl_entry === '0, "R1", int'(dl_entry), 0);
    thresh = 8'd3; co_valid = '1; co_ts = '0;
    repeat (40) @(negedge clk);
    check(deadlock === 1'b0, "R1 no issue", int'(deadlock), 0);

    // R2: age equal to threshold is not stale, one more is
    do_reset(); clear_model();
    vld_a[2] = 1; age_a[2] = 5;
    vld_a[5] = 1; age_a[5] = 6;
    run_scan(5, "R2");

    // R9: invalid entries with large ages
    do_reset(); clear_model();
    for (int p = 0; p < NT; p++) age_a[p] = 200;
    run_scan(4, "R9");

    // R6: merged table scanned before waiting table
    do_reset(); clear_model();
    vld_a[3] = 1; age_a[3] = 50;
    vld_a[4] = 1; age_a[4] = 50;
    run_scan(3, "R6 boundary");
    do_reset(); clear_model();
    vld_a[8] = 1; age_a[8] = 30;
    vld_a[9] = 1; age_a[9] = 30;
    run_scan(2, "R6 waiting table");

    // R4: second issue during pending period is ignored
    do_reset(); clear_model();
    vld_a[0] = 1; age_a[0] = 40;
    thresh = 8'd8;
    pulse_issue();
    c0 = cyc;
    apply_tables(8, c0);
    repeat (2) @(negedge clk);
    issue = 1'b1;
    @(negedge clk) issue = 1'b0;
    repeat (5) @(negedge clk);
    check(deadlock === 1'b0, "R4 early", int'(deadlock), 0);
    @(negedge clk);
    expect_hit(0, "R4");

    // R5: zero threshold never arms
    do_reset();
    thresh = '0; co_valid = '1; uc_valid = '1; co_ts = '0; uc_ts = '0;
    pulse_issue();
    repeat (60) @(negedge clk);
    check(deadlock === 1'b0, "R5", int'(deadlock), 0);

    // R7: rearm while outstanding, then the second scan flags
    do_reset(); clear_model();
    outst = 4'd1;
    thresh = 8'd4;
    pulse_issue();
    c0 = cyc;
    apply_tables(4, c0);
    repeat (4 + NT) @(negedge clk);
    check(deadlock === 1'b0, "R7 first scan", int'(deadlock), 0);
    vld_a[0] = 1; age_a[0] = 100;
    set_entry(0, c0 + 32'd4 + 32'(NT) + 32'd4);
    repeat (4) @(negedge clk);
    check(deadlock === 1'b0, "R7 early", int'(deadlock), 0);
    @(negedge clk);
    expect_hit(0, "R7 rearm");

    // R8: sticky flag ignores later stimulus
    clear_model();
    vld_a[6] = 1; age_a[6] = 100;
    apply_tables(2, cyc);
    thresh = 8'd2;
    pulse_issue();
    repeat (30) @(negedge clk);
    expect_hit(0, "R8");

    // R7: no outstanding requests means idle after a clean scan
    do_reset(); clear_model();
    outst = '0;
    thresh = 8'd4;
    pulse_issue();
    c0 = cyc;
    apply_tables(4, c0);
    repeat (4 + NT) @(negedge clk);
    vld_a[0] = 1; age_a[0] = 100;
    set_entry(0, c0 + 32'd4 + 32'(NT) + 32'd4);
    repeat (30) @(negedge clk);
    check(deadlock === 1'b0, "R7 idle", int'(deadlock), 0);

    // R10: timestamps straddle the counter wrap
    do_reset(); clear_model();
    while (cyc[TS_W-1:0] != 8'd247) @(negedge clk);
    vld_a[0] = 1; age_a[0] = 6;
    vld_a[1] = 1; age_a[1] = 7;
    run_scan(6, "R10");

    // random tables (R2 R3 R6 R9)
    for (int it = 0; it < 40; it++) begin
      int t;
      do_reset(); clear_model();
      t = 1 + int'($urandom % 20);
      for (int p = 0; p < NT; p++) begin
        vld_a[p] = bit'($urandom % 2);
        age_a[p] = int'($urandom % (2 * t + 3));
      end
      run_scan(t, "R2 R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule